// File: doc/BRIEF.md
# Memory-Bus Performance Monitor Counter Bank

This block collects activity statistics for a memory controller. It holds one 64-bit free-running cycle counter and a parameterised number of 32-bit event counters. Each event counter picks one line out of an event pulse vector through a 7-bit select. It adds one in every clock where that line is high and the counter is not frozen. Software reaches every register through a plain 32-bit read/write port with a registered read path.

The global control register holds three bits. The first freezes all counters. The second enables the interrupt. The third lets a counter condition freeze the bank. Each counter has its own control register, which can freeze that counter alone and can arm its overflow condition. An armed overflow is an increment that carries into a counter's top bit. When the interrupt and freeze-on-condition are also enabled, that overflow sets the freeze-all bit by hardware. The whole bank then stops. The interrupt line stays high until software clears the top bit of the offending counter.

The usual software flow has four steps. Freeze the bank, program the selects and clear the counts, then release the freeze. Later, freeze the bank again and read the counts back.

Top module: `pmon_bank`

## Requirements
- R1: After reset the global control register reads 0x8000_0000, which means freeze-all is set and every other bit is clear. Every local control and count register reads 0, and `irq` is low.
- R2: The address map works on byte addresses. The global control register is at 0x40, with bit 31 for freeze-all, bit 30 for interrupt enable and bit 29 for freeze-on-condition. Counter n (0 is the cycle counter) has its control register at 0x50+0x10*n, with bit 31 for local freeze, bit 26 for condition enable and bits 22:16 for the event select. At +4 is a second control word that reads 0 and ignores writes. The count is at +8. The upper half of the cycle counter is at 0x5C. The select field of the cycle counter reads 0. An address with bits 1:0 not zero hits nothing. `bus_rdata` shows the addressed register one clock after `bus_rd` is sampled.
- R3: The cycle counter adds one on every clock in which neither its local freeze nor freeze-all is set, whatever its select value.
- R4: Event counter n adds one in each clock where `evt_in[select]` is high and the counter is not frozen.
- R5: A counter whose local freeze bit is set, or any counter while freeze-all is set, keeps its value.
- R6: A select value of `NUM_EVENTS` or more counts nothing.
- R7: A write to a count register in the same clock as an increment loads the written value, and the increment is lost. Writing zero clears the counter.
- R8: Hardware sets freeze-all in the clock where an increment carries a counter's top bit from 0 to 1, provided that counter's condition enable, interrupt enable and freeze-on-condition are all set. The counter stops at the value with only the top bit set.
- R9: `irq` is registered. It is high one clock after the interrupt enable and freeze-on-condition are set and some counter with condition enable has its top bit set. It falls one clock after this stops being true.
- R10: An overflow of a counter without condition enable neither freezes the bank nor raises `irq`.
- R11: When software clears freeze-all, counting resumes in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | NUM_EVENTS | Event pulse lines, one count per high clock |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The embedded assertions check four things on every cycle. A frozen counter holds its value. An out-of-range select never counts. A count write always wins over an increment. The cycle counter steps by exactly one when free. The global checker adds that a qualified overflow sets freeze-all on the next edge and that `irq` never rises without both global enables. The bench scenarios cover what depends on the whole sequence: the exact number of cycles and events counted between a release and a freeze, the address map and its readback, the two-edge interrupt timing, the difference between armed and unarmed overflows, and resuming after software clears the freeze.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int DATA_W      = 32;
  localparam int GLB_OFS     = 32'h40;
  localparam int CTR_BASE    = 32'h50;
  localparam int SEL_W       = 7;
  localparam int SEL_SPAN    = 1 << SEL_W;
  // bit positions decoded by software
  localparam int B_FRZ_ALL   = 31;
  localparam int B_IRQ_EN    = 30;
  localparam int B_FRZ_COND  = 29;
  localparam int B_LFRZ      = 31;
  localparam int B_CND_EN    = 26;
  localparam int B_SEL_LO    = 16;

  typedef enum logic [1:0] {
    SLOT_CTLA   = 2'd0,
    SLOT_CTLB   = 2'd1,
    SLOT_CNT_LO = 2'd2,
    SLOT_CNT_HI = 2'd3
  } slot_e;

  typedef struct packed {
    logic             frz;
    logic             cnd_en;
    logic [SEL_W-1:0] sel;
  } lctl_t;
endpackage

// File: rtl/pmon_lctl.sv
module pmon_lctl
  import pmon_pkg::*;
#(
  parameter bit HAS_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  lctl_t             wfield,
  output lctl_t             q,
  output logic [DATA_W-1:0] rd_word
);
  logic             frz_q, cnd_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q <= 1'b0;
      cnd_q <= 1'b0;
    end else if (we) begin
      frz_q <= wfield.frz;
      cnd_q <= wfield.cnd_en;
    end
  end

  generate
    if (HAS_SEL) begin : g_sel
      always_ff @(posedge clk) begin
        if (rst)     sel_q <= '0;
        else if (we) sel_q <= wfield.sel;
      end
    end else begin : g_nosel
      assign sel_q = '0;
    end
  endgenerate

  assign q = '{frz: frz_q, cnd_en: cnd_q, sel: sel_q};

  always_comb begin
    rd_word = '0;
    rd_word[B_LFRZ]                  = frz_q;
    rd_word[B_CND_EN]                = cnd_q;
    rd_word[B_SEL_LO +: SEL_W]       = sel_q;
  end
endmodule

// File: rtl/pmon_glb_ctl.sv
module pmon_glb_ctl
  import pmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        wbits,     // {freeze-all, irq enable, freeze on condition}
  input  logic              ovf_rise_any,
  input  logic              cond_any,
  output logic              frz_all,
  output logic              irq,
  output logic [DATA_W-1:0] rd_word
);
  logic irq_en_q, frz_cond_q, hw_set;

  assign hw_set = ovf_rise_any && irq_en_q && frz_cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_all    <= 1'b1;
      irq_en_q   <= 1'b0;
      frz_cond_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (we) begin
        frz_all    <= wbits[2];
        irq_en_q   <= wbits[1];
        frz_cond_q <= wbits[0];
      end
      if (hw_set) frz_all <= 1'b1;
      irq <= irq_en_q && frz_cond_q && cond_any;
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[B_FRZ_ALL]  = frz_all;
    rd_word[B_IRQ_EN]   = irq_en_q;
    rd_word[B_FRZ_COND] = frz_cond_q;
  end

  // R8: a qualified overflow freezes the bank on the next edge
  p_ovf_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> frz_all)
    else $error("p_ovf_freeze_r8");

  // R9: the interrupt needs both global enables in the previous cycle
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(irq_en_q && frz_cond_q))
    else $error("p_irq_gate_r9");
endmodule

// File: rtl/pmon_cyc_ctr.sv
module pmon_cyc_ctr
  import pmon_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frz_all,
  input  logic              lfrz,
  input  logic              cnd_en,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lo_word,
  output logic [DATA_W-1:0] hi_word,
  output logic              ovf_rise,
  output logic              cond
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             run;

  assign run      = !frz_all && !lfrz && !we_lo && !we_hi;
  assign cnt_nxt  = cnt + CNT_W'(1);
  assign ovf_rise = run && cnd_en && !cnt[CNT_W-1] && cnt_nxt[CNT_W-1];
  assign cond     = cnd_en && cnt[CNT_W-1];
  assign lo_word  = cnt[DATA_W-1:0];
  assign hi_word  = DATA_W'(cnt[CNT_W-1:DATA_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (we_lo || we_hi) begin
      if (we_lo) cnt[DATA_W-1:0]     <= wdata;
      if (we_hi) cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
    end else if (run) begin
      cnt <= cnt_nxt;
    end
  end

  // R3: free-running step of exactly one
  p_cycle_step_r3: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == $past(cnt) + CNT_W'(1))
    else $error("p_cycle_step_r3");

  // R7: a write to the low half loads it regardless of counting
  p_cycle_write_r7: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> lo_word == $past(wdata))
    else $error("p_cycle_write_r7");
endmodule

// File: rtl/pmon_evt_ctr.sv
module pmon_evt_ctr
  import pmon_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NUM_EVENTS = 96
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frz_all,
  input  logic                  lfrz,
  input  logic                  cnd_en,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NUM_EVENTS-1:0] evt_in,
  input  logic                  cnt_we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     cnt_word,
  output logic                  ovf_rise,
  output logic                  cond
);
  logic [SEL_SPAN-1:0] evt_pad;
  logic [CNT_W-1:0]    cnt, cnt_nxt;
  logic                hit, run;

  // unconnected select codes see a constant zero
  assign evt_pad  = SEL_SPAN'(evt_in);
  assign hit      = evt_pad[sel];
  assign run      = hit && !frz_all && !lfrz && !cnt_we;
  assign cnt_nxt  = cnt + CNT_W'(1);
  assign ovf_rise = run && cnd_en && !cnt[CNT_W-1] && cnt_nxt[CNT_W-1];
  assign cond     = cnd_en && cnt[CNT_W-1];
  assign cnt_word = DATA_W'(cnt);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (cnt_we) cnt <= wdata[CNT_W-1:0];
    else if (run)    cnt <= cnt_nxt;
  end

  // R5: frozen counters hold
  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ((frz_all || lfrz) && !cnt_we) |=> $stable(cnt))
    else $error("p_freeze_hold_r5");

  // R6: unconnected select never counts
  p_bad_sel_r6: assert property (@(posedge clk) disable iff (rst)
    ((int'(sel) >= NUM_EVENTS) && !cnt_we) |=> $stable(cnt))
    else $error("p_bad_sel_r6");

  // R7: write wins over increment
  p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt == $past(wdata[CNT_W-1:0]))
    else $error("p_write_wins_r7");
endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
  import pmon_pkg::*;
#(
  parameter int NUM_EVT_CTR = 10,
  parameter int EVT_CNT_W   = 32,
  parameter int CYC_CNT_W   = 64,
  parameter int NUM_EVENTS  = 96,
  parameter int ADDR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_EVENTS-1:0] evt_in,
  output logic                  irq
);
  localparam int NUM_CTR = NUM_EVT_CTR + 1;
  localparam int WA_W    = ADDR_W - 2;
  localparam int IDX_W   = WA_W - 2;

  // ---------------- address decode ----------------
  logic [WA_W-1:0]   word_addr, rel;
  logic [IDX_W-1:0]  ctr_idx;
  logic              aligned, glb_hit, in_ctr;
  slot_e             slot;
  logic [NUM_CTR-1:0] ctr_hit;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign word_addr = bus_addr[ADDR_W-1:2];
  assign glb_hit   = aligned && (word_addr == WA_W'(GLB_OFS >> 2));
  assign in_ctr    = aligned && (word_addr >= WA_W'(CTR_BASE >> 2));
  assign rel       = word_addr - WA_W'(CTR_BASE >> 2);
  assign ctr_idx   = rel[WA_W-1:2];
  assign slot      = slot_e'(rel[1:0]);

  lctl_t wfield;
  assign wfield = '{frz:    bus_wdata[B_LFRZ],
                    cnd_en: bus_wdata[B_CND_EN],
                    sel:    bus_wdata[B_SEL_LO +: SEL_W]};

  // ---------------- per-counter state ----------------
  logic [NUM_CTR-1:0] ctl_we, cnt_we, ovf_rise, cond;
  lctl_t              lq      [NUM_CTR];
  logic [DATA_W-1:0]  ctl_word[NUM_CTR];
  logic [DATA_W-1:0]  cnt_word[NUM_CTR];
  logic [DATA_W-1:0]  cyc_hi_word, glb_word;
  logic               frz_all, cyc_we_hi;

  assign cyc_we_hi = bus_wr && ctr_hit[0] && (slot == SLOT_CNT_HI);

  genvar g;
  generate
    for (g = 0; g < NUM_CTR; g++) begin : g_ctr
      assign ctr_hit[g] = in_ctr && (ctr_idx == IDX_W'(g));
      assign ctl_we[g]  = bus_wr && ctr_hit[g] && (slot == SLOT_CTLA);
      assign cnt_we[g]  = bus_wr && ctr_hit[g] && (slot == SLOT_CNT_LO);

      pmon_lctl #(.HAS_SEL(g != 0)) u_lctl (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl_we[g]),
        .wfield  (wfield),
        .q       (lq[g]),
        .rd_word (ctl_word[g])
      );

      if (g == 0) begin : g_cyc
        pmon_cyc_ctr #(.CNT_W(CYC_CNT_W)) u_cyc (
          .clk      (clk),
          .rst      (rst),
          .frz_all  (frz_all),
          .lfrz     (lq[g].frz),
          .cnd_en   (lq[g].cnd_en),
          .we_lo    (cnt_we[g]),
          .we_hi    (cyc_we_hi),
          .wdata    (bus_wdata),
          .lo_word  (cnt_word[g]),
          .hi_word  (cyc_hi_word),
          .ovf_rise (ovf_rise[g]),
          .cond     (cond[g])
        );
      end else begin : g_evt
        pmon_evt_ctr #(.CNT_W(EVT_CNT_W), .NUM_EVENTS(NUM_EVENTS)) u_evt (
          .clk      (clk),
          .rst      (rst),
          .frz_all  (frz_all),
          .lfrz     (lq[g].frz),
          .cnd_en   (lq[g].cnd_en),
          .sel      (lq[g].sel),
          .evt_in   (evt_in),
          .cnt_we   (cnt_we[g]),
          .wdata    (bus_wdata),
          .cnt_word (cnt_word[g]),
          .ovf_rise (ovf_rise[g]),
          .cond     (cond[g])
        );
      end
    end
  endgenerate

  // ---------------- global control ----------------
  pmon_glb_ctl u_glb (
    .clk          (clk),
    .rst          (rst),
    .we           (bus_wr && glb_hit),
    .wbits        (bus_wdata[B_FRZ_ALL:B_FRZ_COND]),
    .ovf_rise_any (|ovf_rise),
    .cond_any     (|cond),
    .frz_all      (frz_all),
    .irq          (irq),
    .rd_word      (glb_word)
  );

  // ---------------- registered read path ----------------
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (glb_hit) rd_mux = glb_word;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (ctr_hit[i]) begin
        case (slot)
          SLOT_CTLA:   rd_mux = ctl_word[i];
          SLOT_CNT_LO: rd_mux = cnt_word[i];
          SLOT_CNT_HI: if (i == 0) rd_mux = cyc_hi_word;
          default:     rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R1: no interrupt while the bank is held in reset state
  p_irq_low_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !irq)
    else $error("p_irq_low_after_reset_r1");
endmodule

// File: tb/pmon_bank_bench.sv
`timescale 1ns/1ps
module pmon_bank_bench;
  localparam int NEV = 96;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_wr, bus_rd;
  logic [7:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NEV-1:0]    evt_in;
  logic              irq;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pmon_bank #(.NUM_EVENTS(NEV)) u_pmon_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq(irq)
  );

  function automatic logic [7:0] a_ctl(int n); return 8'(32'h50 + 16*n); endfunction
  function automatic logic [7:0] a_cnt(int n); return 8'(32'h58 + 16*n); endfunction

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected value to the scoreboard
  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(logic exp, string tag);
    check(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // monitor: compare registered read data after the edge
  initial begin : monitor
    logic seen;
    logic [31:0] e;
    string t;
    forever begin
      @(posedge clk);
      seen = bus_rd;
      #1;
      if (seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard underflow", bus_rdata, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(bus_rdata == e, t, bus_rdata, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stim
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(8'h40, 32'h8000_0000, "R1 global reset");
    rd(a_cnt(0), 32'h0, "R1 cycle lo reset");
    rd(8'h5C, 32'h0, "R1 cycle hi reset");
    rd(a_ctl(1), 32'h0, "R1 ctl1 reset");
    chk_irq(1'b0, "R1 irq reset");

    // map details
    wr(a_ctl(0), 32'h0007_0000);
    wr(8'h64, 32'hFFFF_FFFF);
    rd(a_ctl(0), 32'h0, "R2 cycle select reads zero");
    rd(8'h64, 32'h0, "R2 second control word");
    wr(a_ctl(1), 32'h0003_0000);
    rd(a_ctl(1), 32'h0003_0000, "R2 select readback");
    rd(8'h41, 32'h0, "R2 misaligned address");

    // cycle counter: 10 free clocks
    wr(a_cnt(0), 32'd5);
    wr(8'h40, 32'h0);
    idle(9);
    wr(8'h40, 32'h8000_0000);
    rd(a_cnt(0), 32'd15, "R3 cycle count");
    rd(8'h5C, 32'h0, "R3 cycle hi");

    // event counters
    wr(a_ctl(2), 32'h0005_0000);
    wr(a_ctl(3), 32'h0078_0000);          // select 120, unconnected
    wr(a_ctl(4), 32'h8003_0000);          // locally frozen
    wr(8'h40, 32'h0);
    evt_in = '1;
    idle(4);
    foreach (evt_in[i]) evt_in[i] = 1'b0;
    for (int s = 0; s < 6; s++) begin
      evt_in = '0;
      evt_in[3] = (s == 0) || (s == 2) || (s == 3);
      @(negedge clk);
    end
    evt_in = '0;
    wr(8'h40, 32'h8000_0000);
    rd(a_cnt(1), 32'd7, "R4 counter1 events");
    rd(a_cnt(2), 32'd4, "R4 counter2 events");
    rd(a_cnt(3), 32'd0, "R6 unconnected select");
    rd(a_cnt(4), 32'd0, "R5 local freeze");
    rd(a_cnt(0), 32'd26, "R3 cycle count continued");

    // write priority
    evt_in[3] = 1'b1;
    wr(8'h40, 32'h0);
    wr(a_cnt(1), 32'd100);
    wr(8'h40, 32'h8000_0000);
    evt_in = '0;
    rd(a_cnt(1), 32'd101, "R7 write wins");
    wr(a_cnt(1), 32'd0);
    rd(a_cnt(1), 32'd0, "R7 clear");
    rd(a_cnt(0), 32'd28, "R3 cycle during write test");

    // local freeze on cycle counter, all events high
    wr(a_ctl(0), 32'h8000_0000);
    evt_in = '1;
    wr(8'h40, 32'h0);
    idle(5);
    wr(8'h40, 32'h8000_0000);
    evt_in = '0;
    rd(a_cnt(0), 32'd28, "R5 cycle local freeze");
    rd(a_cnt(1), 32'd6, "R4 counter1 run");
    rd(a_cnt(3), 32'd0, "R6 unconnected select all ones");
    rd(a_cnt(4), 32'd0, "R5 counter4 frozen");
    wr(a_ctl(0), 32'h0);

    // overflow without condition enable
    wr(a_cnt(1), 32'h7FFF_FFFF);
    wr(8'h40, 32'h6000_0000);
    evt_in[3] = 1'b1;
    @(negedge clk);
    evt_in = '0;
    idle(2);
    chk_irq(1'b0, "R10 irq stays low");
    rd(8'h40, 32'h6000_0000, "R10 no freeze");
    wr(8'h40, 32'h8000_0000);
    rd(a_cnt(1), 32'h8000_0000, "R10 counter wrapped to MSB");

    // armed overflow on event counter 2
    wr(a_ctl(2), 32'h0405_0000);
    wr(a_cnt(2), 32'h7FFF_FFFE);
    evt_in[5] = 1'b1;
    wr(8'h40, 32'h6000_0000);
    idle(3);
    chk_irq(1'b1, "R9 irq raised");
    rd(8'h40, 32'hE000_0000, "R8 freeze set by overflow");
    rd(a_cnt(2), 32'h8000_0000, "R8 counter stopped");
    wr(a_cnt(2), 32'h0);
    chk_irq(1'b1, "R9 irq one clock after clear");
    idle(1);
    chk_irq(1'b0, "R9 irq cleared");

    // resume after software clears freeze
    wr(8'h40, 32'h6000_0000);
    idle(1);
    wr(8'h40, 32'h8000_0000);
    evt_in = '0;
    rd(a_cnt(2), 32'd2, "R11 resumed counting");

    // armed overflow on the 64-bit cycle counter
    wr(a_ctl(0), 32'h0400_0000);
    wr(8'h5C, 32'h7FFF_FFFF);
    wr(a_cnt(0), 32'hFFFF_FFFD);
    wr(8'h40, 32'h6000_0000);
    idle(4);
    chk_irq(1'b1, "R9 cycle overflow irq");
    rd(8'h5C, 32'h8000_0000, "R8 cycle hi stopped");
    rd(a_cnt(0), 32'h0, "R8 cycle lo stopped");
    rd(8'h40, 32'hE000_0000, "R8 cycle overflow froze bank");

    idle(2);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule